// File: doc/BRIEF.md
# Descriptor Ring DMA Engine

This block moves data between two rings of buffer descriptors in external memory and a pair of simple word streams. There is one ring for outgoing traffic and one for incoming traffic. Each descriptor is a pair of 32-bit words. The first word carries a hand-over flag, a wrap flag, an end-of-frame flag and a length. The second word points at the data buffer. Driver software fills a descriptor and sets its hand-over flag, then strikes the matching doorbell register. The block then walks the ring from its current position. For each descriptor it streams the buffer out, or fills it from the incoming stream. It then writes the first word back with the hand-over flag cleared, which returns the buffer to software.

Both directions share one memory read/write port, and only one access is in flight at a time. A single enable bit acts as the reset of the descriptor logic. While it is low, both ring positions follow their programmed start addresses and doorbells are discarded. When it rises, a short fixed start-up sequence clears the word counters and reloads the ring positions before any descriptor is fetched.

Top module: `bd_ring_dma`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `mem_req`, `tx_valid`, `tx_last`, `rx_pop`, `rx_end`, `tx_irq` and `rx_irq` are low, and `tx_words` and `rx_words` are zero.
- R2: A descriptor is two words at its ring position. In word 0, bit 31 is the hand-over flag (1 = owned by hardware), bit 29 is wrap, bit 27 is end-of-frame, and bits 15:0 are the length in 32-bit words. Word 1, at position + 4, is the byte address of the buffer.
- R3: For an outgoing descriptor, the block reads `length` consecutive words starting at the buffer address. It presents each word once on `tx_data` with a one-cycle `tx_valid`, in address order. `tx_last` accompanies the final word only when the end-of-frame flag is set.
- R4: For an incoming descriptor, the block writes `length` consecutive words of `rx_data` to the buffer in address order. It pulses `rx_pop` once per stored word, and `rx_end` with the final word. The source presents the next word after each `rx_pop`.
- R5: After the data phase, the block rewrites word 0 with bit 31 cleared and all other bits unchanged. It then raises the direction's interrupt (`tx_irq` or `rx_irq`) for exactly one cycle.
- R6: After a release, the ring position advances by 8 bytes, or returns to the ring start address when the wrap flag was set.
- R7: If a fetched word 0 has bit 31 clear, that direction stops and touches no data. It resumes from the same position only after a write to its doorbell: register address 1 for outgoing, 2 for incoming, with any data value.
- R8: While enable (register address 0, bit 0) is low, there is no data traffic, doorbell writes are discarded, and the ring positions follow the start registers. The outgoing start is at register address 3 and the incoming start at address 4.
- R9: A rising enable runs a start-up sequence before any fetch: clear the outgoing count, clear the incoming count, load the incoming position, load the outgoing position, then zero both counts. `tx_words` and `rx_words` count words streamed in each direction since that sequence.
- R10: A descriptor of length zero moves no data but is still written back and released with an interrupt.
- R11: On the shared port, a request keeps its address, direction and write data stable until `mem_ack`. When both directions are busy they take turns, and both rings complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory access complete |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| tx_valid | output | 1 | Outgoing word valid |
| tx_data | output | 32 | Outgoing word |
| tx_last | output | 1 | Final word of an end-of-frame descriptor |
| rx_pop | output | 1 | Incoming word was consumed |
| rx_end | output | 1 | Incoming buffer filled |
| rx_data | input | 32 | Incoming word |
| tx_irq | output | 1 | Outgoing descriptor released |
| rx_irq | output | 1 | Incoming descriptor released |
| tx_words | output | CNT_W | Outgoing words since start-up |
| rx_words | output | CNT_W | Incoming words since start-up |

## Verification
The hardest condition to reach is a ring position that has wrapped or been reset, because the position itself is not visible at the ports. The stimulus proves each case by placing a hardware-owned descriptor only where the expected position points. It then checks which buffer comes out. Examples are a wrapped ring re-reading its start slot, and a re-enable after the start register moved. A doorbell struck while the block is disabled is checked the same way: an owned descriptor sits at the ring start, and no traffic may appear afterwards. Contention on the shared port is reached by striking both doorbells back to back while both rings hold multi-word descriptors.

// File: rtl/bd_dma_pkg.sv
package bd_dma_pkg;
  localparam int WORD_W    = 32;
  localparam int LEN_W     = 16;
  localparam int OWN_BIT   = 31;
  localparam int WRAP_BIT  = 29;
  localparam int LAST_BIT  = 27;
  localparam int DESC_STEP = 8;
  localparam int WORD_STEP = 4;

  localparam logic [2:0] REG_ENABLE  = 3'd0;
  localparam logic [2:0] REG_TX_BELL = 3'd1;
  localparam logic [2:0] REG_RX_BELL = 3'd2;
  localparam logic [2:0] REG_TX_BASE = 3'd3;
  localparam logic [2:0] REG_RX_BASE = 3'd4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD0,
    ST_RD1,
    ST_DATA,
    ST_WB
  } eng_state_t;
endpackage

// File: rtl/bd_mem_arb.sv
module bd_mem_arb #(
  parameter int ADDR_W = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [1:0]             req,
  input  logic [1:0]             we,
  input  logic [1:0][ADDR_W-1:0] addr,
  input  logic [1:0][31:0]       wdata,
  input  logic                   mem_ack,
  output logic                   mem_req,
  output logic                   mem_we,
  output logic [ADDR_W-1:0]      mem_addr,
  output logic [31:0]            mem_wdata,
  output logic [1:0]             gnt_ack
);
  logic busy;
  logic owner;
  logic last_win;
  logic pick;

  always_comb begin
    pick = 1'b0;
    if (req[1] && (!req[0] || !last_win)) pick = 1'b1;
  end

  assign gnt_ack[0] = busy && mem_ack && !owner;
  assign gnt_ack[1] = busy && mem_ack && owner;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      owner     <= 1'b0;
      last_win  <= 1'b1;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else if (!busy) begin
      if (|req) begin
        busy      <= 1'b1;
        owner     <= pick;
        last_win  <= pick;
        mem_req   <= 1'b1;
        mem_we    <= we[pick];
        mem_addr  <= addr[pick];
        mem_wdata <= wdata[pick];
      end
    end else if (mem_ack) begin
      busy    <= 1'b0;
      mem_req <= 1'b0;
    end
  end
endmodule

// File: rtl/bd_dir_engine.sv
module bd_dir_engine
  import bd_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter bit IS_RX  = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              run,
  input  logic              kick,
  input  logic              load_ptr,
  input  logic              clr_cnt,
  input  logic [ADDR_W-1:0] ring_start,
  input  logic [31:0]       in_data,
  output logic              req,
  output logic              we,
  output logic [ADDR_W-1:0] addr,
  output logic [31:0]       wdata,
  input  logic              ack,
  input  logic [31:0]       rdata,
  output logic              beat,
  output logic              beat_eof,
  output logic              irq,
  output logic [CNT_W-1:0]  words
);
  eng_state_t        st;
  logic [ADDR_W-1:0] ptr;
  logic [ADDR_W-1:0] buf_addr;
  logic [31:0]       w0;
  logic [LEN_W-1:0]  remain;
  logic              pend;

  always_comb begin
    req = (st != ST_IDLE);
    we  = (st == ST_WB) || (IS_RX && st == ST_DATA);
    case (st)
      ST_RD1:  addr = ptr + ADDR_W'(WORD_STEP);
      ST_DATA: addr = buf_addr;
      default: addr = ptr;
    endcase
    wdata    = (st == ST_WB) ? (w0 & ~(32'd1 << OWN_BIT)) : in_data;
    beat     = ack && (st == ST_DATA);
    beat_eof = beat && (remain == LEN_W'(1)) && (IS_RX || w0[LAST_BIT]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      ptr      <= '0;
      buf_addr <= '0;
      w0       <= '0;
      remain   <= '0;
      pend     <= 1'b0;
      irq      <= 1'b0;
      words    <= '0;
    end else begin
      irq <= 1'b0;
      if (clr_cnt) words <= '0;
      else if (beat) words <= words + CNT_W'(1);
      if (!en) begin
        st   <= ST_IDLE;
        pend <= 1'b0;
        ptr  <= ring_start;
      end else begin
        if (kick) pend <= 1'b1;
        if (load_ptr) ptr <= ring_start;
        case (st)
          ST_IDLE: if (run && (pend || kick)) begin
            st   <= ST_RD0;
            pend <= 1'b0;
          end
          ST_RD0: if (ack) begin
            w0 <= rdata;
            st <= rdata[OWN_BIT] ? ST_RD1 : ST_IDLE;
          end
          ST_RD1: if (ack) begin
            buf_addr <= rdata[ADDR_W-1:0];
            remain   <= w0[LEN_W-1:0];
            st       <= (w0[LEN_W-1:0] == '0) ? ST_WB : ST_DATA;
          end
          ST_DATA: if (ack) begin
            buf_addr <= buf_addr + ADDR_W'(WORD_STEP);
            remain   <= remain - LEN_W'(1);
            if (remain == LEN_W'(1)) st <= ST_WB;
          end
          ST_WB: if (ack) begin
            irq <= 1'b1;
            ptr <= w0[WRAP_BIT] ? ring_start : ptr + ADDR_W'(DESC_STEP);
            st  <= ST_RD0;
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/bd_ring_dma.sv
module bd_ring_dma
  import bd_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              tx_valid,
  output logic [31:0]       tx_data,
  output logic              tx_last,
  output logic              rx_pop,
  output logic              rx_end,
  input  logic [31:0]       rx_data,
  output logic              tx_irq,
  output logic              rx_irq,
  output logic [CNT_W-1:0]  tx_words,
  output logic [CNT_W-1:0]  rx_words
);
  localparam int NDIR = 2;
  localparam logic [2:0] INIT_LAST = 3'd5;

  logic                      en_q;
  logic [2:0]                init_step;
  logic [NDIR-1:0][ADDR_W-1:0] ring_base;
  logic [NDIR-1:0]           e_req, e_we, e_ack, e_beat, e_eof, e_irq;
  logic [NDIR-1:0][ADDR_W-1:0] e_addr;
  logic [NDIR-1:0][31:0]     e_wdata;
  logic [NDIR-1:0][CNT_W-1:0] e_words;
  logic [NDIR-1:0]           e_kick, e_load, e_clr;
  logic                      run;

  assign run = en_q && (init_step == 3'd0);

  // start-up order: tx clear, rx clear, rx pointer, tx pointer, counts
  assign e_clr[0]  = (init_step == 3'd1) || (init_step == INIT_LAST);
  assign e_clr[1]  = (init_step == 3'd2) || (init_step == INIT_LAST);
  assign e_load[1] = (init_step == 3'd3);
  assign e_load[0] = (init_step == 3'd4);
  assign e_kick[0] = reg_wr && (reg_addr == REG_TX_BELL);
  assign e_kick[1] = reg_wr && (reg_addr == REG_RX_BELL);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= 1'b0;
      init_step <= 3'd0;
      ring_base <= '0;
    end else begin
      if (init_step != 3'd0)
        init_step <= (init_step == INIT_LAST) ? 3'd0 : init_step + 3'd1;
      if (reg_wr) begin
        case (reg_addr)
          REG_ENABLE: begin
            en_q <= reg_wdata[0];
            if (reg_wdata[0] && !en_q) init_step <= 3'd1;
            else if (!reg_wdata[0]) init_step <= 3'd0;
          end
          REG_TX_BASE: ring_base[0] <= reg_wdata[ADDR_W-1:0];
          REG_RX_BASE: ring_base[1] <= reg_wdata[ADDR_W-1:0];
          default: ;
        endcase
      end
    end
  end

  for (genvar g = 0; g < NDIR; g++) begin : g_dir
    bd_dir_engine #(
      .ADDR_W(ADDR_W),
      .CNT_W (CNT_W),
      .IS_RX (g == 1)
    ) i_eng (
      .clk       (clk),
      .rst       (rst),
      .en        (en_q),
      .run       (run),
      .kick      (e_kick[g]),
      .load_ptr  (e_load[g]),
      .clr_cnt   (e_clr[g]),
      .ring_start(ring_base[g]),
      .in_data   (rx_data),
      .req       (e_req[g]),
      .we        (e_we[g]),
      .addr      (e_addr[g]),
      .wdata     (e_wdata[g]),
      .ack       (e_ack[g]),
      .rdata     (mem_rdata),
      .beat      (e_beat[g]),
      .beat_eof  (e_eof[g]),
      .irq       (e_irq[g]),
      .words     (e_words[g])
    );
  end

  bd_mem_arb #(.ADDR_W(ADDR_W)) i_arb (
    .clk      (clk),
    .rst      (rst),
    .req      (e_req),
    .we       (e_we),
    .addr     (e_addr),
    .wdata    (e_wdata),
    .mem_ack  (mem_ack),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .gnt_ack  (e_ack)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid <= 1'b0;
      tx_last  <= 1'b0;
      tx_data  <= '0;
      rx_pop   <= 1'b0;
      rx_end   <= 1'b0;
    end else begin
      tx_valid <= e_beat[0];
      tx_last  <= e_eof[0];
      if (e_beat[0]) tx_data <= mem_rdata;
      rx_pop   <= e_beat[1];
      rx_end   <= e_eof[1];
    end
  end

  assign tx_irq   = e_irq[0];
  assign rx_irq   = e_irq[1];
  assign tx_words = e_words[0];
  assign rx_words = e_words[1];
endmodule

// File: rtl/bd_ring_dma_chk.sv
module bd_ring_dma_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              en_q,
  input logic              mem_req,
  input logic              mem_ack,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [31:0]       mem_wdata,
  input logic              tx_valid,
  input logic              tx_last,
  input logic              rx_pop,
  input logic              rx_end,
  input logic              tx_irq,
  input logic              rx_irq
);
  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R5
  tx_irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    tx_irq |=> !tx_irq);

  // R5
  rx_irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rx_irq |=> !rx_irq);

  // R8
  quiet_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!en_q && $past(!en_q)) |-> (!tx_valid && !rx_pop));

  // R3
  tx_last_chk: assert property (@(posedge clk) disable iff (rst)
    tx_last |-> tx_valid);

  // R4
  rx_end_chk: assert property (@(posedge clk) disable iff (rst)
    rx_end |-> rx_pop);
endmodule

bind bd_ring_dma bd_ring_dma_chk #(.ADDR_W(ADDR_W)) i_bd_ring_dma_chk (
  .clk      (clk),
  .rst      (rst),
  .en_q     (en_q),
  .mem_req  (mem_req),
  .mem_ack  (mem_ack),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .mem_wdata(mem_wdata),
  .tx_valid (tx_valid),
  .tx_last  (tx_last),
  .rx_pop   (rx_pop),
  .rx_end   (rx_end),
  .tx_irq   (tx_irq),
  .rx_irq   (rx_irq)
);

// File: tb/test_bd_ring_dma.sv
module test_bd_ring_dma;
  localparam int AW = 32;
  localparam int CW = 16;
  localparam logic [31:0] RX_BASE = 32'hA500_0000;
  localparam logic [31:0] BUF_BASE = 32'hD000_0000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_wr = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata;
  logic          mem_ack = 1'b0;
  logic [31:0]   mem_rdata = '0;
  logic          tx_valid, tx_last, rx_pop, rx_end, tx_irq, rx_irq;
  logic [31:0]   tx_data;
  logic [31:0]   rx_data;
  logic [CW-1:0] tx_words, rx_words;

  int vectors = 0;
  int misses = 0;
  int tx_n = 0;
  int rx_n = 0;
  int rx_end_n = 0;
  int tx_irq_n = 0;
  int rx_irq_n = 0;
  logic [31:0] tx_got [0:63];
  logic        tx_lastq [0:63];
  logic [31:0] mem [0:1023];

  always #10 clk = ~clk;

  bd_ring_dma #(.ADDR_W(AW), .CNT_W(CW)) i_bd_ring_dma (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
    .rx_pop(rx_pop), .rx_end(rx_end), .rx_data(rx_data),
    .tx_irq(tx_irq), .rx_irq(rx_irq), .tx_words(tx_words), .rx_words(rx_words)
  );

  assign rx_data = RX_BASE + 32'(rx_n);

  always @(posedge clk) begin
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
      else mem_rdata <= mem[mem_addr[11:2]];
    end else begin
      mem_ack <= 1'b0;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (tx_valid && tx_n < 64) begin
        tx_got[tx_n] = tx_data;
        tx_lastq[tx_n] = tx_last;
        tx_n++;
      end
      if (rx_pop) rx_n++;
      if (rx_end) rx_end_n++;
      if (tx_irq) tx_irq_n++;
      if (rx_irq) rx_irq_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic set_desc(input int a, input logic [31:0] w0, input logic [31:0] w1);
    mem[a >> 2] = w0;
    mem[(a >> 2) + 1] = w1;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    chk(!mem_req && !tx_valid && !rx_pop && !tx_irq && !rx_irq, "R1 outputs in reset", {27'd0, mem_req, tx_valid, rx_pop, tx_irq, rx_irq}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(!mem_req && !tx_last && !rx_end && tx_words == 0 && rx_words == 0, "R1 after reset",
        {tx_words, rx_words}, 32'd0);
  endtask

  task automatic t_basic_tx();
    for (int i = 0; i < 256; i++) mem[256 + i] = BUF_BASE + 32'(i);
    set_desc('h100, 32'h8800_0003, 32'h400);
    set_desc('h108, 32'h0, 32'h0);
    set_desc('h200, 32'h0, 32'h0);
    wr_reg(3'd3, 32'h100);
    wr_reg(3'd4, 32'h200);
    wr_reg(3'd0, 32'h1);
    settle(20);
    chk(tx_words == 0 && rx_words == 0, "R9 counts zero after start-up", {tx_words, rx_words}, 32'd0);
    chk(tx_n == 0, "R7 no traffic before doorbell", 32'(tx_n), 32'd0);
    wr_reg(3'd1, 32'h0);
    settle(200);
    chk(tx_n == 3, "R3 word count", 32'(tx_n), 32'd3);
    for (int i = 0; i < 3; i++)
      chk(tx_got[i] == BUF_BASE + 32'(i), "R3 data order", tx_got[i], BUF_BASE + 32'(i));
    chk({tx_lastq[0], tx_lastq[1], tx_lastq[2]} == 3'b001, "R3 last on final word",
        {29'd0, tx_lastq[0], tx_lastq[1], tx_lastq[2]}, 32'd1);
    chk(mem['h100 >> 2] == 32'h0800_0003, "R5 writeback clears bit 31", mem['h100 >> 2], 32'h0800_0003);
    chk(mem['h104 >> 2] == 32'h400, "R2 pointer word untouched", mem['h104 >> 2], 32'h400);
    chk(tx_irq_n == 1, "R5 one tx interrupt", 32'(tx_irq_n), 32'd1);
    chk(tx_words == 3, "R9 tx word count", 32'(tx_words), 32'd3);
  endtask

  task automatic t_stall_resume();
    set_desc('h108, 32'hA000_0002, 32'h410);
    settle(100);
    chk(tx_n == 3, "R7 stalled until doorbell", 32'(tx_n), 32'd3);
    wr_reg(3'd1, 32'h5);
    settle(200);
    chk(tx_n == 5, "R7 resumed after doorbell", 32'(tx_n), 32'd5);
    chk(tx_got[3] == BUF_BASE + 4 && tx_got[4] == BUF_BASE + 5, "R3 second buffer data", tx_got[4], BUF_BASE + 5);
    chk(!tx_lastq[3] && !tx_lastq[4], "R3 no last without flag", {31'd0, tx_lastq[4]}, 32'd0);
    chk(mem['h108 >> 2] == 32'h2000_0002, "R5 writeback keeps wrap and length", mem['h108 >> 2], 32'h2000_0002);
    set_desc('h100, 32'h8800_0001, 32'h420);
    wr_reg(3'd1, 32'h0);
    settle(200);
    chk(tx_n == 6 && tx_got[5] == BUF_BASE + 8, "R6 wrap back to ring start", tx_got[5], BUF_BASE + 8);
  endtask

  task automatic t_dual();
    set_desc('h200, 32'hA000_0004, 32'h600);
    set_desc('h108, 32'hA800_0002, 32'h430);
    wr_reg(3'd1, 32'h0);
    wr_reg(3'd2, 32'h0);
    settle(300);
    chk(rx_n == 4 && rx_end_n == 1, "R4 pops and end", 32'(rx_n), 32'd4);
    for (int i = 0; i < 4; i++)
      chk(mem[('h600 >> 2) + i] == RX_BASE + 32'(i), "R4 stored data", mem[('h600 >> 2) + i], RX_BASE + 32'(i));
    chk(mem['h200 >> 2] == 32'h2000_0004, "R5 rx writeback", mem['h200 >> 2], 32'h2000_0004);
    chk(rx_irq_n == 1 && rx_words == 4, "R11 rx side completed", 32'(rx_words), 32'd4);
    chk(tx_n == 8 && tx_got[6] == BUF_BASE + 12 && tx_got[7] == BUF_BASE + 13 && tx_lastq[7],
        "R11 tx side completed under contention", tx_got[7], BUF_BASE + 13);
  endtask

  task automatic t_zero_len();
    mem['h700 >> 2] = 32'h5555_5555;
    set_desc('h200, 32'hA000_0000, 32'h700);
    wr_reg(3'd2, 32'h0);
    settle(100);
    chk(rx_n == 4, "R10 no data moved", 32'(rx_n), 32'd4);
    chk(mem['h700 >> 2] == 32'h5555_5555, "R10 buffer untouched", mem['h700 >> 2], 32'h5555_5555);
    chk(mem['h200 >> 2] == 32'h2000_0000 && rx_irq_n == 2, "R10 still released", mem['h200 >> 2], 32'h2000_0000);
  endtask

  task automatic t_disable();
    wr_reg(3'd0, 32'h0);
    set_desc('h100, 32'h8800_0001, 32'h440);
    wr_reg(3'd1, 32'h0);
    settle(100);
    chk(tx_n == 8, "R8 doorbell ignored while off", 32'(tx_n), 32'd8);
    set_desc('h180, 32'h8800_0001, 32'h448);
    wr_reg(3'd3, 32'h180);
    wr_reg(3'd0, 32'h1);
    settle(20);
    chk(tx_words == 0 && tx_n == 8, "R9 restart clears count, no stale doorbell", 32'(tx_words), 32'd0);
    wr_reg(3'd1, 32'h0);
    settle(200);
    chk(tx_n == 9 && tx_got[8] == BUF_BASE + 18, "R8 pointer follows new start", tx_got[8], BUF_BASE + 18);
    chk(mem['h100 >> 2] == 32'h8800_0001, "R8 old ring slot not touched", mem['h100 >> 2], 32'h8800_0001);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    misses++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    t_reset();
    t_basic_tx();
    t_stall_resume();
    t_dual();
    t_zero_len();
    t_disable();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule